// File: doc/BRIEF.md
# Pulse-Cycle Phase Sequencer

This block paces a pulsed RF controller through one fixed cycle of phases: waiting for a trigger, an idle gap, a one-tick gap, converter warmup, feedforward drive, closed-loop drive, decay capture and a retrigger hold-off. Software programs a length for each programmable phase through a small write port. The sequencer presents the current phase number together with decoded enable strobes for the data path, and it emits a one-cycle strobe when a pulse begins.

Two timebases are used. The phases from idle through decay are counted in fine ticks of `FINE_DIV` clocks. The trigger-wait phase is counted in coarse ticks of `COARSE_DIV` clocks. The hold-off phase is not given a length. Instead it is given an end time, counted in coarse ticks from the moment the idle phase was entered, so the total pulse repetition period stays fixed however long the active phases last. A halt input parks the sequencer in the wait phase, and a self-retrigger input lets the wait phase time out and start the next pulse without an external trigger. A trigger that cannot be accepted produces a one-cycle skipped-trigger error.

Top module: `rfcyc_sequencer`

## Requirements
- R1: After reset `state_o` is 0, every strobe, enable and `skip_err_o` is low, and every length slot holds 0.
- R2: In phase 0, with `self_retrig_i` low and `halt_i` low, the sequencer stays in phase 0 until `trig_i` is seen high at a clock edge; it then shows phase 1 from the next cycle.
- R3: The phases follow the order 0, 1, 2, 3, 4, 5, 6, 7 and then 0 again, as shown on `state_o`. The codes are 0 wait, 1 idle, 2 gap, 3 warmup, 4 feedforward, 5 closed loop, 6 decay and 7 hold-off.
- R4: Phases 1, 3, 4, 5 and 6 with programmed length L last max(L,1)*FINE_DIV clocks, so a length of 0 means one tick. Phase 2 always lasts FINE_DIV clocks.
- R5: Let E be the programmed end time and let the first cycle of phase 1 be cycle 0. Phase 7 is left after the first cycle t in phase 7 with t >= E*COARSE_DIV. Phase 7 always lasts at least one clock.
- R6: With `self_retrig_i` high, phase 0 with programmed length L lasts max(L,1)*COARSE_DIV clocks and is then followed by phase 1.
- R7: While `halt_i` is high, the cycle after it is seen shows phase 0. The sequencer stays in phase 0 regardless of `trig_i` or `self_retrig_i`.
- R8: A `trig_i` seen outside phase 0, or while `halt_i` is high, raises `skip_err_o` for exactly the next cycle. An accepted trigger leaves `skip_err_o` low.
- R9: `pulse_start_o` is high exactly in the first cycle of phase 1 and at no other time.
- R10: `warm_en_o` is high only in phase 3. `drive_en_o` is high in phases 4 and 5. `loop_en_o` is high only in phase 5. `decay_en_o` is high only in phase 6.
- R11: A write with `wr_sel_i` = k loads slot k with `wr_data_i`. Slot k is the length of phase k for k in {0,1,3,4,5,6}, and slot 7 is the hold-off end time. A write to slot 2 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | External pulse trigger, sampled each edge |
| halt_i | input | 1 | Park in phase 0 |
| self_retrig_i | input | 1 | Let phase 0 time out and start a pulse |
| wr_en_i | input | 1 | Length slot write strobe |
| wr_sel_i | input | 3 | Slot index for the write |
| wr_data_i | input | LEN_W | Value to write |
| state_o | output | 3 | Current phase code |
| pulse_start_o | output | 1 | First cycle of a pulse |
| warm_en_o | output | 1 | Converter warmup phase |
| drive_en_o | output | 1 | Feedforward drive active |
| loop_en_o | output | 1 | Closed-loop phase |
| decay_en_o | output | 1 | Decay capture phase |
| skip_err_o | output | 1 | Trigger was not accepted |

## Verification
A stale tick counter or a prescaler that does not restart on a phase change shows up as a phase that runs a few clocks too long or too short. The bench measures the length of every phase run to the exact clock, so such an error appears within the same pulse. A timebase cleared at the wrong moment moves the end of phase 7 by whole coarse ticks, and the checked hold-off length exposes it. A wrong next-phase decode breaks the observed order on `state_o` or fails to return to phase 0 within one clock of halt, and that is caught on the following cycle.

// File: rtl/rfcyc_pkg.sv
package rfcyc_pkg;
   typedef enum logic [2:0] {
      ST_WAIT  = 3'd0,
      ST_IDLE  = 3'd1,
      ST_GAP   = 3'd2,
      ST_WARM  = 3'd3,
      ST_FFWD  = 3'd4,
      ST_LOOP  = 3'd5,
      ST_DECAY = 3'd6,
      ST_HOLD  = 3'd7
   } seq_state_e;

   localparam int unsigned NUM_SLOTS = 8;
   localparam int unsigned FIXED_SLOT = 2;
   localparam int unsigned END_SLOT = 7;
endpackage

// File: rtl/rfcyc_prescaler.sv
module rfcyc_prescaler #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   generate
      if (DIV <= 1) begin : g_pass
         assign tick = 1'b1;
      end else begin : g_count
         localparam int unsigned CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt_q;

         assign tick = (cnt_q == LAST);

         always_ff @(posedge clk) begin
            if (!rst_n || clr || tick) cnt_q <= '0;
            else                       cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/rfcyc_len_regs.sv
module rfcyc_len_regs
   import rfcyc_pkg::*;
#(
   parameter int unsigned LEN_W = 12
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [2:0]                      wr_sel,
   input  logic [LEN_W-1:0]                wr_data,
   output logic [NUM_SLOTS-1:0][LEN_W-1:0] len_q
);
   generate
      for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
         if (k == FIXED_SLOT) begin : g_fixed
            assign len_q[k] = '0;
         end else begin : g_reg
            always_ff @(posedge clk) begin
               if (!rst_n)                            len_q[k] <= '0;
               else if (wr_en && wr_sel == 3'(k))     len_q[k] <= wr_data;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/rfcyc_phase_timer.sv
module rfcyc_phase_timer #(
   parameter int unsigned LEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic [LEN_W-1:0] limit,
   output logic             expire
);
   localparam logic [LEN_W-1:0] CNT_MAX = '1;

   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W:0]   need;
   logic [LEN_W:0]   reached;

   assign need    = (limit == '0) ? (LEN_W+1)'(1) : {1'b0, limit};
   assign reached = {1'b0, cnt_q} + (LEN_W+1)'(1);
   assign expire  = tick && (reached >= need);

   always_ff @(posedge clk) begin
      if (!rst_n || clr)                  cnt_q <= '0;
      else if (tick && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/rfcyc_timebase.sv
module rfcyc_timebase #(
   parameter int unsigned LEN_W = 12,
   parameter int unsigned DIV   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   output logic [LEN_W-1:0] elapsed
);
   localparam logic [LEN_W-1:0] SAT = '1;
   logic unit_tick;

   rfcyc_prescaler #(.DIV(DIV)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr),
      .tick (unit_tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || clr)                 elapsed <= '0;
      else if (unit_tick && elapsed != SAT) elapsed <= elapsed + 1'b1;
   end
endmodule

// File: rtl/rfcyc_sequencer.sv
module rfcyc_sequencer
   import rfcyc_pkg::*;
#(
   parameter int unsigned LEN_W      = 12,
   parameter int unsigned FINE_DIV   = 4,
   parameter int unsigned COARSE_DIV = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_i,
   input  logic             halt_i,
   input  logic             self_retrig_i,
   input  logic             wr_en_i,
   input  logic [2:0]       wr_sel_i,
   input  logic [LEN_W-1:0] wr_data_i,
   output logic [2:0]       state_o,
   output logic             pulse_start_o,
   output logic             warm_en_o,
   output logic             drive_en_o,
   output logic             loop_en_o,
   output logic             decay_en_o,
   output logic             skip_err_o
);
   generate
      if (LEN_W < 2 || LEN_W > 24) begin : g_bad_len
         $error("rfcyc_sequencer: LEN_W out of range");
      end
      if (FINE_DIV < 1) begin : g_bad_fine
         $error("rfcyc_sequencer: FINE_DIV must be at least 1");
      end
      if (COARSE_DIV < FINE_DIV) begin : g_bad_coarse
         $error("rfcyc_sequencer: COARSE_DIV must not be below FINE_DIV");
      end
   endgenerate

   seq_state_e                     state_q, state_d;
   logic [NUM_SLOTS-1:0][LEN_W-1:0] len_q;
   logic [LEN_W-1:0]               limit;
   logic [LEN_W-1:0]               elapsed;
   logic [2:0]                     st_idx;
   logic                           chg, fine_tick, coarse_tick, sel_tick;
   logic                           expire, enter_idle, trig_ok;

   rfcyc_len_regs #(.LEN_W(LEN_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en_i),
      .wr_sel (wr_sel_i),
      .wr_data(wr_data_i),
      .len_q  (len_q)
   );

   assign chg = (state_d != state_q);

   rfcyc_prescaler #(.DIV(FINE_DIV)) u_fine (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (chg),
      .tick (fine_tick)
   );

   rfcyc_prescaler #(.DIV(COARSE_DIV)) u_coarse (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (chg),
      .tick (coarse_tick)
   );

   assign st_idx   = state_q;
   assign sel_tick = (state_q == ST_WAIT) ? coarse_tick : fine_tick;
   assign limit    = len_q[st_idx];

   rfcyc_phase_timer #(.LEN_W(LEN_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (chg),
      .tick  (sel_tick),
      .limit (limit),
      .expire(expire)
   );

   assign enter_idle = (state_d == ST_IDLE) && (state_q != ST_IDLE);

   rfcyc_timebase #(.LEN_W(LEN_W), .DIV(COARSE_DIV)) u_tbase (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (enter_idle),
      .elapsed(elapsed)
   );

   assign trig_ok = trig_i && !halt_i && (state_q == ST_WAIT);

   always_comb begin
      state_d = state_q;
      if (halt_i) begin
         state_d = ST_WAIT;
      end else begin
         unique case (state_q)
            ST_WAIT:  if (trig_ok || (self_retrig_i && expire)) state_d = ST_IDLE;
            ST_IDLE:  if (expire) state_d = ST_GAP;
            ST_GAP:   if (expire) state_d = ST_WARM;
            ST_WARM:  if (expire) state_d = ST_FFWD;
            ST_FFWD:  if (expire) state_d = ST_LOOP;
            ST_LOOP:  if (expire) state_d = ST_DECAY;
            ST_DECAY: if (expire) state_d = ST_HOLD;
            ST_HOLD:  if (elapsed >= len_q[END_SLOT]) state_d = ST_WAIT;
            default:  state_d = ST_WAIT;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q       <= ST_WAIT;
         pulse_start_o <= 1'b0;
         skip_err_o    <= 1'b0;
      end else begin
         state_q       <= state_d;
         pulse_start_o <= (state_q == ST_WAIT) && (state_d == ST_IDLE);
         skip_err_o    <= trig_i && !trig_ok;
      end
   end

   assign state_o    = state_q;
   assign warm_en_o  = (state_q == ST_WARM);
   assign drive_en_o = (state_q == ST_FFWD) || (state_q == ST_LOOP);
   assign loop_en_o  = (state_q == ST_LOOP);
   assign decay_en_o = (state_q == ST_DECAY);
endmodule

// File: rtl/rfcyc_sequencer_chk.sv
module rfcyc_sequencer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       trig_i,
   input logic       halt_i,
   input logic [2:0] state_o,
   input logic       pulse_start_o,
   input logic       warm_en_o,
   input logic       drive_en_o,
   input logic       loop_en_o,
   input logic       decay_en_o,
   input logic       skip_err_o
);
   p_halt_parks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      halt_i |=> (state_o == 3'd0));

   p_skip_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && (halt_i || state_o != 3'd0)) |=> skip_err_o);

   p_accept_no_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && !halt_i && state_o == 3'd0) |=> (!skip_err_o && pulse_start_o));

   p_step_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!halt_i && state_o != 3'd7) |=>
         (state_o == $past(state_o) || state_o == $past(state_o) + 3'd1));

   p_hold_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!halt_i && state_o == 3'd7) |=> (state_o == 3'd7 || state_o == 3'd0));

   p_start_in_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_start_o |-> (state_o == 3'd1));

   p_one_phase_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({warm_en_o, loop_en_o, decay_en_o}) && !(drive_en_o && (warm_en_o || decay_en_o)));
endmodule

bind rfcyc_sequencer rfcyc_sequencer_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .trig_i       (trig_i),
   .halt_i       (halt_i),
   .state_o      (state_o),
   .pulse_start_o(pulse_start_o),
   .warm_en_o    (warm_en_o),
   .drive_en_o   (drive_en_o),
   .loop_en_o    (loop_en_o),
   .decay_en_o   (decay_en_o),
   .skip_err_o   (skip_err_o)
);

// File: tb/sim_rfcyc_sequencer.sv
module sim_rfcyc_sequencer;
   localparam int LW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          trig = 1'b0, halt = 1'b0, selfr = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_sel = '0;
   logic [LW-1:0] wr_data = '0;
   logic [2:0]    state;
   logic          pstart, warm, drive, loopen, decay, skip;

   int n_cmp = 0, n_bad = 0;
   int dur [8];
   int ord_bad, ps_bad, en_bad;

   always #2 clk = ~clk;

   rfcyc_sequencer u0 (
      .clk(clk), .rst_n(rst_n), .trig_i(trig), .halt_i(halt), .self_retrig_i(selfr),
      .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
      .state_o(state), .pulse_start_o(pstart), .warm_en_o(warm), .drive_en_o(drive),
      .loop_en_o(loopen), .decay_en_o(decay), .skip_err_o(skip)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   task automatic wr(input logic [2:0] sel, input int val);
      @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = LW'(val);
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic fire();
      @(negedge clk); trig = 1'b1;
      @(negedge clk); trig = 1'b0;
   endtask

   task automatic wait_state(input logic [2:0] s);
      for (int i = 0; i < 5000 && state != s; i++) @(negedge clk);
   endtask

   function automatic int en_ok(input logic [2:0] s);
      return (warm == (s == 3'd3)) && (drive == (s == 3'd4 || s == 3'd5)) &&
             (loopen == (s == 3'd5)) && (decay == (s == 3'd6));
   endfunction

   // Starts at the sampled first cycle of phase 1; returns at the first cycle of phase 0.
   task automatic trace_cycle();
      logic [2:0] prev = 3'd1;
      int cnt = 1;
      for (int k = 0; k < 8; k++) dur[k] = 0;
      ord_bad = 0; ps_bad = (pstart == 1'b1) ? 0 : 1; en_bad = en_ok(state) ? 0 : 1;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (!en_ok(state)) en_bad++;
         if (pstart) ps_bad++;
         if (state == prev) cnt++;
         else begin
            dur[prev] = cnt;
            if (!(state == prev + 3'd1 || (prev == 3'd7 && state == 3'd0))) ord_bad++;
            prev = state; cnt = 1;
            if (state == 3'd0) break;
         end
      end
   endtask

   task automatic t_reset();
      chk("R1 state", int'(state), 0);
      chk("R1 outputs", int'({pstart, warm, drive, loopen, decay, skip}), 0);
   endtask

   task automatic t_zero_lengths();
      fire();
      chk("R2 trigger starts", int'(state), 1);
      chk("R8 accepted no skip", int'(skip), 0);
      trace_cycle();
      for (int k = 1; k <= 6; k++) chk("R1 R4 zero length one tick", dur[k], 4);
      chk("R5 hold min one clock", dur[7], 1);
      chk("R3 order", ord_bad, 0);
      chk("R9 start strobe", ps_bad, 0);
      chk("R10 enables", en_bad, 0);
   endtask

   task automatic t_stay_idle();
      repeat (200) @(negedge clk);
      chk("R2 no trigger stays", int'(state), 0);
   endtask

   task automatic t_programmed();
      wr(3'd0, 3); wr(3'd1, 2); wr(3'd3, 1); wr(3'd4, 0);
      wr(3'd5, 3); wr(3'd6, 2); wr(3'd7, 5); wr(3'd2, 7);
      fire();
      trace_cycle();
      chk("R4 idle", dur[1], 8);
      chk("R11 gap slot ignored", dur[2], 4);
      chk("R4 warm", dur[3], 4);
      chk("R4 feedforward", dur[4], 4);
      chk("R4 loop", dur[5], 12);
      chk("R4 decay", dur[6], 8);
      chk("R5 hold end 5", dur[7], 41);
      chk("R3 order", ord_bad, 0);
      chk("R10 enables", en_bad, 0);
      wr(3'd7, 3);
      fire();
      trace_cycle();
      chk("R5 hold end 3", dur[7], 9);
   endtask

   task automatic t_self_and_halt();
      int c0 = 1;
      wr(3'd0, 2);
      @(negedge clk); selfr = 1'b1;
      fire();
      trace_cycle();
      for (int i = 0; i < 2000 && state == 3'd0; i++) begin
         @(negedge clk);
         if (state == 3'd0) c0++;
      end
      chk("R6 self retrigger wait", c0, 32);
      chk("R9 start after retrigger", int'(pstart), 1);
      halt = 1'b1;
      @(negedge clk);
      chk("R7 halt to wait", int'(state), 0);
      repeat (100) @(negedge clk);
      chk("R7 halt holds", int'(state), 0);
      trig = 1'b1;
      @(negedge clk); trig = 1'b0;
      chk("R8 halted trigger skipped", int'(skip), 1);
      chk("R7 halted trigger ignored", int'(state), 0);
      selfr = 1'b0; halt = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_halt_mid();
      fire();
      wait_state(3'd5);
      halt = 1'b1;
      @(negedge clk);
      chk("R7 halt from loop", int'(state), 0);
      halt = 1'b0;
      repeat (20) @(negedge clk);
      chk("R7 stays after release", int'(state), 0);
   endtask

   task automatic t_skip();
      fire();
      wait_state(3'd3);
      trig = 1'b1;
      @(negedge clk); trig = 1'b0;
      chk("R8 skip raised", int'(skip), 1);
      chk("R8 phase unaffected", int'(state), 3);
      @(negedge clk);
      chk("R8 skip one cycle", int'(skip), 0);
      wait_state(3'd0);
      chk("R3 returns to wait", int'(state), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_zero_lengths();
      t_stay_idle();
      t_programmed();
      t_self_and_halt();
      t_halt_mid();
      t_skip();
      repeat (5) @(negedge clk);
      summary();
   end
endmodule